// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Parallel Read Port

This block is the digital half of a 16-bit successive-approximation converter. A behavioural sample input stands in for the analog front end and the bit-decision comparator. A falling edge on the active-low convert strobe takes a snapshot of the sample and raises `busy_o`. The conversion then runs for a number of system clocks set by a speed-mode select. When `busy_o` drops, the snapshot moves into the result register, so the value read afterwards belongs to the conversion that just finished.

The result is read through a parallel port gated by an active-low chip select and an active-low read strobe. The port either presents the full 16-bit word or works as an 8-bit port that hands out the two bytes in turn, and a swap input picks which byte comes out first. A coding input chooses straight binary or two's complement. An initialisation input lets the host abort a running conversion. Releasing it clears the result and marks the start-up sequence with a short busy pulse.

The data lines come with a per-port drive flag (`drive_o`). The pad tri-state buffer sits outside this block. The data lines read zero whenever `drive_o` is low.

Top module: `sar_ctrl_top`

## Requirements
- R1: A high-to-low change on `cnv_n_i` seen while idle, with `pwrdn_i` and `init_i` low, sets `busy_o` at the next clock edge. `busy_o` then stays high for exactly the conversion length of the selected speed, counted in clocks.
- R2: `speed_i` selects the conversion length: 2'b00 gives 8 clocks, 2'b01 gives 12 clocks, and 2'b10 or 2'b11 gives 20 clocks. The setting is taken when the conversion starts.
- R3: While a conversion runs, further convert-strobe edges and `pwrdn_i` have no effect. The conversion keeps its length and its result.
- R4: While idle, a convert-strobe falling edge that arrives with `pwrdn_i` high starts nothing.
- R5: The result register takes the `sample_i` value captured at the start clock, and it changes only when `busy_o` falls. A read during a conversion returns the previous result.
- R6: With `twos_i` high the presented value has bit 15 inverted (two's complement). With `twos_i` low it is straight binary.
- R7: In word mode (`byte_mode_i` low), one clock after `cs_n_i` and `rd_n_i` are both low, `drive_o` is high and `data_o` carries the full coded result.
- R8: In byte mode, `data_o[15:8]` is zero and `data_o[7:0]` carries one byte. The first byte is bits 15:8 when `swap_i` is low and bits 7:0 when it is high. Each rising `rd_n_i` with `cs_n_i` low moves to the other byte. The sequence restarts at the first byte whenever a new result is loaded or an initialisation happens.
- R9: If `cs_n_i` or `rd_n_i` is high, `drive_o` is low and `data_o` is zero one clock later.
- R10: A high `init_i` aborts any conversion: `busy_o` is low one clock later, the aborted sample is never loaded, and the port is not driven while `init_i` is high.
- R11: When `init_i` falls, the result is cleared to zero and `busy_o` is high for 4 clocks. Convert strobes during that pulse are ignored.
- R12: Synchronous reset `rst` leaves `busy_o`, `drive_o` and `data_o` at zero and the result register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_n_i | input | 1 | Convert strobe, falling edge starts a conversion |
| init_i | input | 1 | Initialisation: high aborts, falling edge starts the start-up pulse |
| pwrdn_i | input | 1 | Power-down request, blocks new starts while idle |
| speed_i | input | 2 | Speed mode select |
| sample_i | input | 16 | Behavioural sample standing in for the analog front end |
| twos_i | input | 1 | Output coding: 1 = two's complement, 0 = straight binary |
| byte_mode_i | input | 1 | 1 = 8-bit port, 0 = 16-bit port |
| swap_i | input | 1 | Byte mode: 1 = low byte first |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| busy_o | output | 1 | Conversion or initialisation in progress |
| drive_o | output | 1 | Data lines are to be driven |
| data_o | output | 16 | Parallel data |

## Verification
The assertions assume that the control inputs are synchronous to `clk` and settle between edges. They also assume that reset is held for at least one edge, so the edge-detect registers hold real values before any property is armed. The bench changes every input at the falling clock edge and leaves a run of reset cycles at the start. It raises `init_i` only at a known count of busy cycles, so the truncated busy length of an aborted conversion can be predicted exactly. Each burst of extra strobes or power-down during a conversion is scheduled to land strictly inside the busy window.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SPD_FAST = 2'b00,
    SPD_NORM = 2'b01,
    SPD_LOW  = 2'b10
  } speed_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CONV,
    PH_INIT,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/sar_edge.sv
module sar_edge (
  input  logic clk,
  input  logic d,
  output logic fall
);
  logic d_q;

  // Follows the input on every edge, reset or not, so the first sample is real
  always_ff @(posedge clk) d_q <= d;

  assign fall = d_q & ~d;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W        = 16,
  parameter int LEN_FAST = 8,
  parameter int LEN_NORM = 12,
  parameter int LEN_LOW  = 20,
  parameter int INIT_LEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_fall,
  input  logic         init_i,
  input  logic         pwrdn_i,
  input  logic [1:0]   speed_i,
  input  logic [W-1:0] sample_i,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] result_o
);
  localparam int MAXL = (LEN_LOW > LEN_NORM) ?
                        ((LEN_LOW > LEN_FAST) ? LEN_LOW : LEN_FAST) :
                        ((LEN_NORM > LEN_FAST) ? LEN_NORM : LEN_FAST);
  localparam int LMAX = (MAXL > INIT_LEN) ? MAXL : INIT_LEN;
  localparam int CW   = $clog2(LMAX + 1);

  phase_e         phase;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   hold;
  logic [CW-1:0]  len_sel;

  always_comb begin
    unique case (speed_i)
      SPD_FAST: len_sel = CW'(LEN_FAST - 1);
      SPD_NORM: len_sel = CW'(LEN_NORM - 1);
      default:  len_sel = CW'(LEN_LOW - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      busy_o   <= 1'b0;
      load_o   <= 1'b0;
      hold     <= '0;
      result_o <= '0;
    end else begin
      load_o <= 1'b0;
      if (init_i) begin
        // abort and wait for release
        phase  <= PH_HOLD;
        busy_o <= 1'b0;
      end else begin
        unique case (phase)
          PH_HOLD: begin
            phase    <= PH_INIT;
            busy_o   <= 1'b1;
            cnt      <= CW'(INIT_LEN - 1);
            result_o <= '0;
            load_o   <= 1'b1;
          end
          PH_IDLE: begin
            if (start_fall && !pwrdn_i) begin
              phase  <= PH_CONV;
              busy_o <= 1'b1;
              cnt    <= len_sel;
              hold   <= sample_i;
            end
          end
          default: begin
            if (cnt == '0) begin
              busy_o <= 1'b0;
              phase  <= PH_IDLE;
              if (phase == PH_CONV) begin
                result_o <= hold;
                load_o   <= 1'b1;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_port.sv
module sar_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] result_i,
  input  logic         load_i,
  input  logic         init_i,
  input  logic         twos_i,
  input  logic         byte_mode_i,
  input  logic         swap_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  output logic         drive_o,
  output logic [W-1:0] data_o
);
  localparam int H = W / 2;

  logic         rd_q;
  logic         ptr;
  logic         rd_end;
  logic         en;
  logic [W-1:0] coded;
  logic [H-1:0] byte_sel;

  assign coded    = {result_i[W-1] ^ twos_i, result_i[W-2:0]};
  assign rd_end   = ~rd_q & rd_n_i & ~cs_n_i;
  assign en       = ~cs_n_i & ~rd_n_i & ~init_i;
  assign byte_sel = (ptr ^ swap_i) ? coded[H-1:0] : coded[W-1:H];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b1;
      ptr     <= 1'b0;
      drive_o <= 1'b0;
      data_o  <= '0;
    end else begin
      rd_q <= rd_n_i;
      if (load_i || init_i)
        ptr <= 1'b0;
      else if (byte_mode_i && rd_end)
        ptr <= ~ptr;
      drive_o <= en;
      if (!en)
        data_o <= '0;
      else if (byte_mode_i)
        data_o <= {{(W-H){1'b0}}, byte_sel};
      else
        data_o <= coded;
    end
  end
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top #(
  parameter int W        = 16,
  parameter int LEN_FAST = 8,
  parameter int LEN_NORM = 12,
  parameter int LEN_LOW  = 20,
  parameter int INIT_LEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnv_n_i,
  input  logic         init_i,
  input  logic         pwrdn_i,
  input  logic [1:0]   speed_i,
  input  logic [W-1:0] sample_i,
  input  logic         twos_i,
  input  logic         byte_mode_i,
  input  logic         swap_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  output logic         busy_o,
  output logic         drive_o,
  output logic [W-1:0] data_o
);
  logic         start_fall;
  logic         load;
  logic [W-1:0] result;

  sar_edge u_cnv_edge (
    .clk  (clk),
    .d    (cnv_n_i),
    .fall (start_fall)
  );

  sar_seq #(
    .W(W), .LEN_FAST(LEN_FAST), .LEN_NORM(LEN_NORM),
    .LEN_LOW(LEN_LOW), .INIT_LEN(INIT_LEN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_fall (start_fall),
    .init_i     (init_i),
    .pwrdn_i    (pwrdn_i),
    .speed_i    (speed_i),
    .sample_i   (sample_i),
    .busy_o     (busy_o),
    .load_o     (load),
    .result_o   (result)
  );

  sar_port #(.W(W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .result_i    (result),
    .load_i      (load),
    .init_i      (init_i),
    .twos_i      (twos_i),
    .byte_mode_i (byte_mode_i),
    .swap_i      (swap_i),
    .cs_n_i      (cs_n_i),
    .rd_n_i      (rd_n_i),
    .drive_o     (drive_o),
    .data_o      (data_o)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnv_n_i,
  input logic         init_i,
  input logic         pwrdn_i,
  input logic         cs_n_i,
  input logic         rd_n_i,
  input logic         byte_mode_i,
  input logic         busy_o,
  input logic         drive_o,
  input logic [W-1:0] data_o
);
  // R1
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnv_n_i) && !cnv_n_i && !busy_o && !pwrdn_i &&
     !init_i && !$past(init_i)) |=> busy_o);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (!busy_o && !drive_o));

  // R11
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(init_i)) |=> busy_o);

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_o |-> (data_o == '0));

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i || rd_n_i) |=> !drive_o);

  // R8
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    byte_mode_i |=> (data_o[W-1:W/2] == '0));
endmodule

bind sar_ctrl_top sar_ctrl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnv_n_i     (cnv_n_i),
  .init_i      (init_i),
  .pwrdn_i     (pwrdn_i),
  .cs_n_i      (cs_n_i),
  .rd_n_i      (rd_n_i),
  .byte_mode_i (byte_mode_i),
  .busy_o      (busy_o),
  .drive_o     (drive_o),
  .data_o      (data_o)
);

// File: tb/test_sar_ctrl_top.sv
module test_sar_ctrl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnv_n_i = 1'b1;
  logic        init_i = 1'b0;
  logic        pwrdn_i = 1'b0;
  logic [1:0]  speed_i = 2'b00;
  logic [15:0] sample_i = '0;
  logic        twos_i = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic        swap_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        rd_n_i = 1'b1;
  logic        busy_o;
  logic        drive_o;
  logic [15:0] data_o;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int busy_run = 0;

  always #5 clk = ~clk;

  sar_ctrl_top i_sar_ctrl_top (
    .clk(clk), .rst(rst), .cnv_n_i(cnv_n_i), .init_i(init_i),
    .pwrdn_i(pwrdn_i), .speed_i(speed_i), .sample_i(sample_i),
    .twos_i(twos_i), .byte_mode_i(byte_mode_i), .swap_i(swap_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .busy_o(busy_o),
    .drive_o(drive_o), .data_o(data_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: measures each busy window and compares with the queued length
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) busy_run++;
      else if (busy_run > 0) begin
        if (exp_q.size() == 0) chk("R1 unexpected busy window", busy_run, 0);
        else chk("R1/R2 busy length", busy_run, exp_q.pop_front());
        busy_run = 0;
      end
    end
  end

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // Driver: starts a conversion and pushes the expected busy length
  task automatic convert(logic [15:0] smp, logic [1:0] spd, int len);
    sample_i = smp;
    speed_i  = spd;
    cnv_n_i  = 1'b0;
    exp_q.push_back(len);
    @(negedge clk);
    cnv_n_i  = 1'b1;
    sample_i = ~smp;              // R5: later sample changes must not matter
    chk("R1 busy after start", busy_o, 1);
    wait_idle();
  endtask

  task automatic read_word(string req, logic [15:0] exp);
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    @(negedge clk);
    chk({req, " drive"}, drive_o, 1);
    chk(req, data_o, exp);
    rd_n_i = 1'b1; cs_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_byte(string req, logic [15:0] exp);
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    @(negedge clk);
    chk(req, data_o, exp);
    rd_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12
    chk("R12 busy", busy_o, 0);
    chk("R12 drive", drive_o, 0);
    chk("R12 data", data_o, 0);
    read_word("R12 cleared result", 16'h0000);

    // R1 R2 R5 R7
    convert(16'hA5C3, 2'b00, 8);
    read_word("R7 word read", 16'hA5C3);
    // R6
    twos_i = 1'b1;
    read_word("R6 twos", 16'h25C3);
    twos_i = 1'b0;
    convert(16'h8001, 2'b01, 12);
    read_word("R2 normal result", 16'h8001);
    convert(16'h7FFE, 2'b11, 20);
    read_word("R2 low-power result", 16'h7FFE);
    twos_i = 1'b1;
    read_word("R6 twos msb set", 16'hFFFE);
    twos_i = 1'b0;

    // R3 and R5: extra strobe, power-down and a read inside the window
    sample_i = 16'h1111; speed_i = 2'b00; cnv_n_i = 1'b0;
    exp_q.push_back(8);
    @(negedge clk); cnv_n_i = 1'b1; sample_i = 16'h2222;
    @(negedge clk); cnv_n_i = 1'b0; pwrdn_i = 1'b1;
    @(negedge clk); cnv_n_i = 1'b1; cs_n_i = 1'b0; rd_n_i = 1'b0;
    @(negedge clk);
    chk("R5 read during conversion", data_o, 16'h7FFE);
    chk("R3 still busy", busy_o, 1);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    wait_idle();
    @(negedge clk);
    chk("R3 no restart", busy_o, 0);
    pwrdn_i = 1'b0;
    read_word("R3 R5 result", 16'h1111);

    // R4
    pwrdn_i = 1'b1; sample_i = 16'h3333; cnv_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 no start in power-down", busy_o, 0);
    cnv_n_i = 1'b1; pwrdn_i = 1'b0;
    @(negedge clk);
    read_word("R4 result kept", 16'h1111);

    // R8
    byte_mode_i = 1'b1; swap_i = 1'b0;
    convert(16'hC3A5, 2'b00, 8);
    read_byte("R8 first byte high", 16'h00C3);
    read_byte("R8 second byte low", 16'h00A5);
    cs_n_i = 1'b1;
    swap_i = 1'b1;
    convert(16'h5AF0, 2'b00, 8);
    read_byte("R8 swapped first", 16'h00F0);
    read_byte("R8 swapped second", 16'h005A);
    read_byte("R8 wraps", 16'h00F0);
    cs_n_i = 1'b1; byte_mode_i = 1'b0; swap_i = 1'b0;
    @(negedge clk);

    // R9
    cs_n_i = 1'b0; rd_n_i = 1'b1;
    @(negedge clk);
    chk("R9 rd high drive", drive_o, 0);
    chk("R9 rd high data", data_o, 0);
    cs_n_i = 1'b1; rd_n_i = 1'b0;
    @(negedge clk);
    chk("R9 cs high drive", drive_o, 0);
    chk("R9 cs high data", data_o, 0);
    rd_n_i = 1'b1;

    // R10 R11
    sample_i = 16'h4444; speed_i = 2'b10; cnv_n_i = 1'b0;
    exp_q.push_back(3);
    @(negedge clk); cnv_n_i = 1'b1;
    @(negedge clk);
    @(negedge clk); init_i = 1'b1; cs_n_i = 1'b0; rd_n_i = 1'b0;
    @(negedge clk);
    chk("R10 abort busy", busy_o, 0);
    chk("R10 bus off", drive_o, 0);
    @(negedge clk);
    chk("R10 bus off held", drive_o, 0);
    init_i = 1'b0;
    exp_q.push_back(4);
    @(negedge clk);
    chk("R11 init pulse", busy_o, 1);
    cnv_n_i = 1'b0;
    @(negedge clk); cnv_n_i = 1'b1;
    wait_idle();
    chk("R11 result cleared", data_o, 16'h0000);
    chk("R11 bus back", drive_o, 1);
    cs_n_i = 1'b1; rd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 no start during init", busy_o, 0);
    chk("R1 all windows seen", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule